// File: doc/BRIEF.md
# Shadow-Set Banked Integer Register File

This block is an integer register file that keeps several banked copies of the 32 architectural registers, one copy per shadow set, and a small group of special registers that all sets share. A logical register number together with a set selector picks the physical entry. Numbers 1 to 31 land in the bank of the selected set. Numbers from 32 upward land in the shared special area, which sits after the last bank. Register 0 is hard-wired to zero in every bank.

Normal instructions use two combinational read ports and one synchronous write port. All three work through the current-set register, which has its own load port and readback output. A second pair of ports, one for reading and one for writing, addresses the bank named by a previous-set input instead. These cross-set ports work only when the architecture-revision input is 1 or greater. Otherwise any request on them raises a reserved-instruction flag for one cycle and changes nothing.

A set number that names no existing bank is never folded into another bank or into the special area. The access raises the error output, its write is dropped, and its read returns zero. The same happens for a register number beyond the last special register.

Top module: `shadow_regfile`

## Requirements
- R1: A logical number r in 1..31 addresses physical entry r + 32*set, where set is the current-set value (4 banks by default). A value written in one set is not visible in the same register number of another set.
- R2: Logical numbers 32..39 are the special registers, numbered from 32 in this order: LO, HI, then six DSP accumulator words. Special register k = r - 32 lives at physical entry 128 + k, and every set sees the same one.
- R3: Register 0 reads as zero through both normal read ports and the cross-set read port, in every set. Writes to it through either write port are discarded.
- R4: Reset clears the current set to 0 and every entry to 0. While css_we is high at a clock edge, css_q takes css_wdata at that edge; otherwise css_q holds its value.
- R5: With arch_rev >= 1, the cross-set ports address entry r + 32*prev_set for r in 0..31. The cross-set write takes effect at the clock edge, and the cross-set read is combinational.
- R6: With arch_rev == 0, a cycle in which xs_rd_en or xs_wr_en is high makes ri_flag high in the following cycle only. The cross-set write is dropped and xs_rd_data reads 0.
- R7: If an access names a bank at or above the bank count (set values 4..7), or a register number of 40 or more, acc_err is high in the same cycle, the write is dropped and the read data is 0. Register numbers 0..39 in banks 0..3 raise no error.
- R8: A read of the entry being written in the same cycle returns the old value. The new value is visible after the clock edge.
- R9: If the normal write port and the cross-set write port hit the same physical entry in the same cycle, the normal port's data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 6 | Read port A logical register number |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 6 | Read port B logical register number |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Normal write enable |
| wr_idx | input | 6 | Normal write logical register number |
| wr_data | input | 32 | Normal write data |
| css_we | input | 1 | Load enable for the current-set register |
| css_wdata | input | 3 | New current-set value |
| css_q | output | 3 | Current-set readback |
| prev_set | input | 3 | Bank used by the cross-set ports |
| arch_rev | input | 3 | Architecture revision; 0 disables cross-set access |
| xs_rd_en | input | 1 | Cross-set read request |
| xs_rd_idx | input | 5 | Cross-set read register number |
| xs_rd_data | output | 32 | Cross-set read data |
| xs_wr_en | input | 1 | Cross-set write request |
| xs_wr_idx | input | 5 | Cross-set write register number |
| xs_wr_data | input | 32 | Cross-set write data |
| acc_err | output | 1 | Access named a missing bank or register |
| ri_flag | output | 1 | Reserved-instruction pulse for a rejected cross-set request |

## Verification
The assertions assume that reset is applied before the first useful edge and that inputs settle well before each clock edge. The bench changes every input 1 ns after a rising edge and samples 1 ns after that. The storage checks also assume the index mapper is the only source of write addresses. The bench therefore reaches out-of-range banks only through css_wdata and prev_set values 4..7, and out-of-range register numbers only through the read and write index ports. The check that both write ports hit the same entry is built by pointing prev_set and the current set at the same bank on purpose.

// File: rtl/srf_pkg.sv
package srf_pkg;
  localparam int ARCH_REGS = 32;

  // Position of each shared special register after the architectural range.
  typedef enum int {
    SPR_LO      = 0,
    SPR_HI      = 1,
    SPR_DSP_X0  = 2,
    SPR_DSP_L1  = 3,
    SPR_DSP_H1  = 4,
    SPR_DSP_X1  = 5,
    SPR_DSP_L2  = 6,
    SPR_DSP_H2  = 7
  } spec_reg_e;
endpackage

// File: rtl/srf_index_map.sv
module srf_index_map #(
  parameter int NUM_SETS = 4,
  parameter int SET_W    = 3,
  parameter int NUM_SPEC = 8,
  parameter int IDX_W    = 6,
  parameter int ADDR_W   = 8
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [SET_W-1:0]  set_sel,
  output logic [ADDR_W-1:0] phys,
  output logic              ok,
  output logic              is_zero
);
  localparam int ARCH = srf_pkg::ARCH_REGS;

  function automatic int bank_entry(input int r, input int s);
    return s * ARCH + r;
  endfunction

  function automatic int spec_entry(input int r);
    return NUM_SETS * ARCH + (r - ARCH);
  endfunction

  always_comb begin
    phys    = '0;
    ok      = 1'b0;
    is_zero = 1'b0;
    if (int'(idx) < ARCH) begin
      is_zero = (idx == '0);
      ok      = int'(set_sel) < NUM_SETS;
      if (ok) phys = ADDR_W'(bank_entry(int'(idx), int'(set_sel)));
    end else if (int'(idx) < ARCH + NUM_SPEC) begin
      ok   = 1'b1;
      phys = ADDR_W'(spec_entry(int'(idx)));
    end
  end
endmodule

// File: rtl/srf_bank_store.sv
module srf_bank_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 136,
  parameter int ADDR_W = 8,
  parameter int NRD    = 3,
  parameter int BANKED = 128
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we_main,
  input  logic [ADDR_W-1:0]             wa_main,
  input  logic [DATA_W-1:0]             wd_main,
  input  logic                          we_xs,
  input  logic [ADDR_W-1:0]             wa_xs,
  input  logic [DATA_W-1:0]             wd_xs,
  input  logic [NRD-1:0][ADDR_W-1:0]    ra,
  output logic [NRD-1:0][DATA_W-1:0]    rd
);
  localparam int ARCH = srf_pkg::ARCH_REGS;

  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic hit_main, hit_xs;
    assign hit_main = we_main && (int'(wa_main) == e);
    assign hit_xs   = we_xs && (int'(wa_xs) == e);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mem[e] <= '0;
      else if (hit_main) mem[e] <= wd_main;   // main port has priority
      else if (hit_xs)   mem[e] <= wd_xs;
    end
  end

  for (genvar k = 0; k < NRD; k++) begin : g_rd
    assign rd[k] = mem[ra[k]];
  end

  AST_NO_ZERO_SLOT_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (we_main && int'(wa_main) < BANKED) |-> (int'(wa_main) % ARCH != 0)); // R3
  AST_NO_ZERO_SLOT_XS: assert property (@(posedge clk) disable iff (!rst_n)
    (we_xs && int'(wa_xs) < BANKED) |-> (int'(wa_xs) % ARCH != 0)); // R3
  AST_WRITE_IN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (we_main || we_xs) |-> (int'(we_main ? wa_main : wa_xs) < DEPTH)); // R7
endmodule

// File: rtl/srf_set_ctrl.sv
module srf_set_ctrl #(
  parameter int SET_W = 3,
  parameter int REV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             css_we,
  input  logic [SET_W-1:0] css_wdata,
  output logic [SET_W-1:0] css_q,
  input  logic [REV_W-1:0] arch_rev,
  input  logic             xs_req,
  output logic             rev_ok,
  output logic             ri_flag
);
  logic xs_reject;

  assign rev_ok    = (arch_rev != '0);
  assign xs_reject = xs_req && !rev_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      css_q   <= '0;
      ri_flag <= 1'b0;
    end else begin
      if (css_we) css_q <= css_wdata;
      ri_flag <= xs_reject;
    end
  end

  AST_CSS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    css_we |=> (css_q == $past(css_wdata))); // R4
  AST_CSS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !css_we |=> $stable(css_q)); // R4
  AST_RI_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (xs_req && arch_rev == '0) |=> ri_flag); // R6
  AST_RI_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !(xs_req && arch_rev == '0) |=> !ri_flag); // R6
endmodule

// File: rtl/shadow_regfile.sv
module shadow_regfile #(
  parameter int DATA_W   = 32,
  parameter int NUM_SETS = 4,
  parameter int SET_W    = 3,
  parameter int NUM_SPEC = 8,
  parameter int REV_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [5:0]        rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [5:0]        rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [5:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              css_we,
  input  logic [SET_W-1:0]  css_wdata,
  output logic [SET_W-1:0]  css_q,
  input  logic [SET_W-1:0]  prev_set,
  input  logic [REV_W-1:0]  arch_rev,
  input  logic              xs_rd_en,
  input  logic [4:0]        xs_rd_idx,
  output logic [DATA_W-1:0] xs_rd_data,
  input  logic              xs_wr_en,
  input  logic [4:0]        xs_wr_idx,
  input  logic [DATA_W-1:0] xs_wr_data,
  output logic              acc_err,
  output logic              ri_flag
);
  localparam int ARCH   = srf_pkg::ARCH_REGS;
  localparam int IDX_W  = 6;
  localparam int BANKED = NUM_SETS * ARCH;
  localparam int DEPTH  = BANKED + NUM_SPEC;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int NPORT  = 5;
  localparam int P_RA = 0, P_RB = 1, P_WR = 2, P_XR = 3, P_XW = 4;

  logic [NPORT-1:0][IDX_W-1:0]  m_idx;
  logic [NPORT-1:0][SET_W-1:0]  m_set;
  logic [NPORT-1:0][ADDR_W-1:0] m_phys;
  logic [NPORT-1:0]             m_ok, m_zero;
  logic                         rev_ok;

  assign m_idx[P_RA] = rd_a_idx;
  assign m_idx[P_RB] = rd_b_idx;
  assign m_idx[P_WR] = wr_idx;
  assign m_idx[P_XR] = {1'b0, xs_rd_idx};
  assign m_idx[P_XW] = {1'b0, xs_wr_idx};
  assign m_set[P_RA] = css_q;
  assign m_set[P_RB] = css_q;
  assign m_set[P_WR] = css_q;
  assign m_set[P_XR] = prev_set;
  assign m_set[P_XW] = prev_set;

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    srf_index_map #(
      .NUM_SETS(NUM_SETS), .SET_W(SET_W), .NUM_SPEC(NUM_SPEC),
      .IDX_W(IDX_W), .ADDR_W(ADDR_W)
    ) u_map (
      .idx(m_idx[p]), .set_sel(m_set[p]),
      .phys(m_phys[p]), .ok(m_ok[p]), .is_zero(m_zero[p])
    );
  end

  srf_set_ctrl #(.SET_W(SET_W), .REV_W(REV_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .css_we(css_we), .css_wdata(css_wdata), .css_q(css_q),
    .arch_rev(arch_rev), .xs_req(xs_rd_en || xs_wr_en),
    .rev_ok(rev_ok), .ri_flag(ri_flag)
  );

  // Named write strobes after gating by validity, zero register and revision.
  logic we_main, we_xs;
  assign we_main = wr_en && m_ok[P_WR] && !m_zero[P_WR];
  assign we_xs   = xs_wr_en && rev_ok && m_ok[P_XW] && !m_zero[P_XW];

  logic [2:0][ADDR_W-1:0] st_ra;
  logic [2:0][DATA_W-1:0] st_rd;
  assign st_ra[0] = m_phys[P_RA];
  assign st_ra[1] = m_phys[P_RB];
  assign st_ra[2] = m_phys[P_XR];

  srf_bank_store #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .NRD(3), .BANKED(BANKED)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .we_main(we_main), .wa_main(m_phys[P_WR]), .wd_main(wr_data),
    .we_xs(we_xs), .wa_xs(m_phys[P_XW]), .wd_xs(xs_wr_data),
    .ra(st_ra), .rd(st_rd)
  );

  logic rd_a_live, rd_b_live, xs_rd_live;
  assign rd_a_live  = m_ok[P_RA] && !m_zero[P_RA];
  assign rd_b_live  = m_ok[P_RB] && !m_zero[P_RB];
  assign xs_rd_live = rev_ok && m_ok[P_XR] && !m_zero[P_XR];

  assign rd_a_data  = rd_a_live  ? st_rd[0] : '0;
  assign rd_b_data  = rd_b_live  ? st_rd[1] : '0;
  assign xs_rd_data = xs_rd_live ? st_rd[2] : '0;

  assign acc_err = !m_ok[P_RA] || !m_ok[P_RB] || (wr_en && !m_ok[P_WR]) ||
                   (rev_ok && xs_rd_en && !m_ok[P_XR]) ||
                   (rev_ok && xs_wr_en && !m_ok[P_XW]);

  AST_ZERO_READ_A: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == '0) |-> (rd_a_data == '0)); // R3
  AST_ZERO_READ_XS: assert property (@(posedge clk) disable iff (!rst_n)
    (xs_rd_idx == '0) |-> (xs_rd_data == '0)); // R3
  AST_ERR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_a_idx) >= ARCH + NUM_SPEC) |-> (acc_err && rd_a_data == '0)); // R7
  AST_XS_REV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (arch_rev == '0) |-> (xs_rd_data == '0)); // R6
endmodule

// File: tb/tb_shadow_regfile.sv
`timescale 1ns/1ps
module tb_shadow_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
  logic        wr_en = 1'b0, css_we = 1'b0;
  logic [2:0]  css_wdata = '0, css_q, prev_set = '0, arch_rev = 3'd1;
  logic        xs_rd_en = 1'b0, xs_wr_en = 1'b0;
  logic [4:0]  xs_rd_idx = '0, xs_wr_idx = '0;
  logic [31:0] xs_rd_data, xs_wr_data = '0;
  logic        acc_err, ri_flag;

  always #4 clk = ~clk;   // 125 MHz

  shadow_regfile dut (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .css_we(css_we), .css_wdata(css_wdata), .css_q(css_q),
    .prev_set(prev_set), .arch_rev(arch_rev),
    .xs_rd_en(xs_rd_en), .xs_rd_idx(xs_rd_idx), .xs_rd_data(xs_rd_data),
    .xs_wr_en(xs_wr_en), .xs_wr_idx(xs_wr_idx), .xs_wr_data(xs_wr_data),
    .acc_err(acc_err), .ri_flag(ri_flag)
  );

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic [31:0] model [136];

  typedef struct packed {
    logic [1:0]  s;
    logic [5:0]  r;
    logic [31:0] d;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{2'd0, 6'd5,  32'h1111_0005},
    '{2'd1, 6'd5,  32'h2222_0005},
    '{2'd2, 6'd5,  32'h3333_0005},
    '{2'd3, 6'd31, 32'h4444_001F},
    '{2'd0, 6'd0,  32'hDEAD_BEEF},
    '{2'd2, 6'd32, 32'h1000_0020},
    '{2'd3, 6'd33, 32'h2000_0021},
    '{2'd1, 6'd39, 32'h3000_0027}
  };

  // Bench-side placement: specials after four banks, banks concatenated.
  function automatic int slot(input int s, input int r);
    if (r >= 32) return 128 + (r - 32);
    return (s << 5) | r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic load_css(input logic [2:0] s);
    css_we = 1'b1; css_wdata = s;
    step();
    css_we = 1'b0;
  endtask

  task automatic write_reg(input logic [5:0] r, input logic [31:0] d);
    wr_en = 1'b1; wr_idx = r; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 136; i++) model[i] = '0;
    #20; rst_n = 1'b1;
    step();

    // R4: reset state
    chk("R4 css_q after reset", {29'd0, css_q}, 32'd0);
    chk("R4 ri_flag after reset", {31'd0, ri_flag}, 32'd0);
    rd_a_idx = 6'd5; rd_b_idx = 6'd33; #1;
    chk("R4 entry cleared a", rd_a_data, 32'd0);
    chk("R4 entry cleared b", rd_b_data, 32'd0);
    chk("R7 no error in range", {31'd0, acc_err}, 32'd0);

    // Table-driven writes across sets
    for (int i = 0; i < 8; i++) begin
      load_css({1'b0, TBL[i].s});
      chk("R4 css_q readback", {29'd0, css_q}, {30'd0, TBL[i].s});
      write_reg(TBL[i].r, TBL[i].d);
      if (TBL[i].r != 0) model[slot(int'(TBL[i].s), int'(TBL[i].r))] = TBL[i].d;
    end

    // Read every table register back in every set
    for (int s = 0; s < 4; s++) begin
      load_css(3'(s));
      for (int i = 0; i < 8; i++) begin
        rd_a_idx = TBL[i].r; rd_b_idx = TBL[i].r; #1;
        if (TBL[i].r == 0) begin
          chk("R3 reg0 port a", rd_a_data, 32'd0);
          chk("R3 reg0 port b", rd_b_data, 32'd0);
        end else if (TBL[i].r >= 32) begin
          chk("R2 shared special a", rd_a_data, model[slot(s, int'(TBL[i].r))]);
          chk("R2 shared special b", rd_b_data, model[slot(s, int'(TBL[i].r))]);
        end else begin
          chk("R1 banked a", rd_a_data, model[slot(s, int'(TBL[i].r))]);
          chk("R1 banked b", rd_b_data, model[slot(s, int'(TBL[i].r))]);
        end
      end
    end

    // R8: read during write returns old value
    load_css(3'd0);
    wr_en = 1'b1; wr_idx = 6'd5; wr_data = 32'hABCD_0005; rd_a_idx = 6'd5; #1;
    chk("R8 old value same cycle", rd_a_data, 32'h1111_0005);
    step(); wr_en = 1'b0; #1;
    chk("R8 new value after edge", rd_a_data, 32'hABCD_0005);

    // R5: cross-set write/read through prev_set
    arch_rev = 3'd1; prev_set = 3'd2;
    xs_wr_en = 1'b1; xs_wr_idx = 5'd9; xs_wr_data = 32'h5555_0009;
    step(); xs_wr_en = 1'b0;
    xs_rd_en = 1'b1; xs_rd_idx = 5'd9; #1;
    chk("R5 cross read prev set", xs_rd_data, 32'h5555_0009);
    rd_a_idx = 6'd9; #1;
    chk("R5 current set 0 untouched", rd_a_data, 32'd0);
    xs_rd_idx = 5'd0; #1;
    chk("R3 cross read reg0", xs_rd_data, 32'd0);
    xs_rd_en = 1'b0;
    load_css(3'd2); rd_a_idx = 6'd9; #1;
    chk("R5 visible in set 2", rd_a_data, 32'h5555_0009);

    // R3: cross-set write to reg 0 discarded
    xs_wr_en = 1'b1; xs_wr_idx = 5'd0; xs_wr_data = 32'hFFFF_FFFF;
    step(); xs_wr_en = 1'b0; rd_a_idx = 6'd0; #1;
    chk("R3 cross write reg0", rd_a_data, 32'd0);

    // R9: both writes to the same entry (css=2, prev_set=2, reg 7)
    wr_en = 1'b1; wr_idx = 6'd7; wr_data = 32'hAAAA_0007;
    xs_wr_en = 1'b1; xs_wr_idx = 5'd7; xs_wr_data = 32'hBBBB_0007;
    step(); wr_en = 1'b0; xs_wr_en = 1'b0; rd_a_idx = 6'd7; #1;
    chk("R9 normal port wins", rd_a_data, 32'hAAAA_0007);

    // R6: revision 0 rejects cross-set access
    arch_rev = 3'd0; prev_set = 3'd2;
    xs_rd_en = 1'b1; xs_rd_idx = 5'd9; #1;
    chk("R6 cross read zero at rev0", xs_rd_data, 32'd0);
    xs_rd_en = 1'b0;
    xs_wr_en = 1'b1; xs_wr_idx = 5'd9; xs_wr_data = 32'h6666_0009;
    step(); xs_wr_en = 1'b0;
    chk("R6 ri pulse", {31'd0, ri_flag}, 32'd1);
    rd_a_idx = 6'd9; #1;
    chk("R6 write dropped", rd_a_data, 32'h5555_0009);
    step();
    chk("R6 ri one cycle", {31'd0, ri_flag}, 32'd0);
    arch_rev = 3'd1;

    // R7: out-of-range current set
    load_css(3'd5);
    chk("R4 css readback 5", {29'd0, css_q}, 32'd5);
    rd_a_idx = 6'd5; rd_b_idx = 6'd32; #1;
    chk("R7 err on bad set", {31'd0, acc_err}, 32'd1);
    chk("R7 bad set reads zero", rd_a_data, 32'd0);
    chk("R2 special still reachable", rd_b_data, model[slot(0, 32)]);
    write_reg(6'd5, 32'hEEEE_0005);
    for (int s = 0; s < 4; s++) begin
      load_css(3'(s)); rd_a_idx = 6'd5; rd_b_idx = 6'd0; #1;
      chk("R7 bad-set write suppressed", rd_a_data,
          (s == 0) ? 32'hABCD_0005 : model[slot(s, 5)]);
    end
    for (int i = 0; i < 8; i++) begin
      rd_a_idx = 6'(32 + i); #1;
      chk("R7 specials untouched", rd_a_data, model[128 + i]);
    end

    // R7: out-of-range register number and prev_set
    rd_a_idx = 6'd45; #1;
    chk("R7 err idx 45", {31'd0, acc_err}, 32'd1);
    chk("R7 idx 45 reads zero", rd_a_data, 32'd0);
    write_reg(6'd45, 32'h7777_7777);
    rd_a_idx = 6'd0; prev_set = 3'd6; xs_rd_en = 1'b1; xs_rd_idx = 5'd9; #1;
    chk("R7 err bad prev_set", {31'd0, acc_err}, 32'd1);
    chk("R7 bad prev_set reads zero", xs_rd_data, 32'd0);
    xs_rd_en = 1'b0; #1;
    chk("R7 err clears", {31'd0, acc_err}, 32'd0);

    finish_run();
  end
endmodule